// File: doc/BRIEF.md
# Channel-Indexed Flag Command Block

This block keeps three banks of per-channel flags for up to 64 channels: error flags, interrupt-request flags and start flags. Software does not change them with a bit mask. It writes an 8-bit command byte that holds a channel number to one of three write-only command offsets. The command either clears one error flag, clears one interrupt flag or sets one start flag. If the channel number is 64 or higher, the command acts on every flag in that bank at once.

Hardware event vectors raise error and interrupt flags. A downstream transfer engine watches the start flags and drops a flag through its own per-channel clear vector once it has taken the request. A parameter selects a full 64-channel build or a reduced 32-channel build. In the reduced build, channel numbers 32 to 63 are reserved: a command that names one of them changes nothing. Every update appears on the status ports one clock after the write or event that causes it.

Top module: `chan_flag_cmd`

## Requirements
- R1: After reset every error, interrupt and start flag reads 0 on the status ports.
- R2: A write to offset 0x1D whose channel field (wr_data[6:0]) is 0 to NUM_CH-1 clears only that channel's error flag, visible one clock later.
- R3: A write to offset 0x1D whose channel field is 64 to 127 clears every error flag in both 32-channel halves.
- R4: A write to offset 0x1F with a channel field of 0 to NUM_CH-1 clears only that channel's interrupt flag.
- R5: A write to offset 0x1F with a channel field of 64 to 127 clears every interrupt flag.
- R6: A write to offset 0x1B sets the indexed channel's start flag, or every start flag when the channel field is 64 to 127.
- R7: wr_data[7] is reserved. Its value never changes which flags a command affects.
- R8: A 1 on err_evt or irq_evt raises that flag one clock later. When the event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R9: With NUM_CH=32, a command with a channel field of 32 to 63 changes no flag, and the high-half status ports always read 0.
- R10: A write to any other offset, or a cycle with wr_en low, changes no flag.
- R11: A 1 on start_clr clears that channel's start flag. A same-cycle software set of the same channel wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 8 | Command byte: [7] reserved, [6:0] channel field |
| err_evt | input | 64 | Per-channel error event pulses |
| irq_evt | input | 64 | Per-channel interrupt event pulses |
| start_clr | input | 64 | Per-channel start acknowledge from the engine |
| err_hi | output | 32 | Error flags, channels 63..32 |
| err_lo | output | 32 | Error flags, channels 31..0 |
| irq_hi | output | 32 | Interrupt flags, channels 63..32 |
| irq_lo | output | 32 | Interrupt flags, channels 31..0 |
| start_flags | output | 64 | Start flags, one per channel |

## Verification
The hardest case to create is a cycle in which a flag receives a set and a clear at the same time. Examples are an error event arriving during a single-channel clear of the same channel, and a start command meeting the engine's acknowledge. The driver raises both inputs at the same negative edge so that both are sampled at one rising edge. The same stimulus goes to a 64-channel instance and a 32-channel instance. This way a single channel number, such as 40 or 63, lands in the normal range of one instance and the reserved range of the other.

// File: rtl/chan_flag_pkg.sv
package chan_flag_pkg;

  localparam int unsigned MAX_CH = 64;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned IDX_W  = 7;

  typedef logic [MAX_CH-1:0] chan_vec_t;

  // Flags that exist in a build with nch channels.
  function automatic chan_vec_t valid_mask(int unsigned nch);
    chan_vec_t v;
    for (int unsigned k = 0; k < MAX_CH; k++) v[k] = (k < nch);
    return v;
  endfunction

  // Channel field -> flag selection: global at 64..127, single below nch, none otherwise.
  function automatic chan_vec_t idx_to_mask(logic [IDX_W-1:0] idx, int unsigned nch);
    chan_vec_t m;
    m = '0;
    if (idx[IDX_W-1]) m = valid_mask(nch);
    else if (32'(idx) < nch) m[idx[IDX_W-2:0]] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
  import chan_flag_pkg::*;
#(
  parameter int unsigned NUM_CH        = 64,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned OFS_CLR_ERR   = 'h1D,
  parameter int unsigned OFS_CLR_IRQ   = 'h1F,
  parameter int unsigned OFS_SET_START = 'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output chan_vec_t         clr_err_m,
  output chan_vec_t         clr_irq_m,
  output chan_vec_t         set_start_m
);

  logic [IDX_W-1:0] idx;
  chan_vec_t        sel;
  logic             hit_err, hit_irq, hit_start;

  always_comb begin
    idx       = wr_data[IDX_W-1:0];   // wr_data[7] is reserved and never looked at
    sel       = idx_to_mask(idx, NUM_CH);
    hit_err   = wr_en && (wr_addr == ADDR_W'(OFS_CLR_ERR));
    hit_irq   = wr_en && (wr_addr == ADDR_W'(OFS_CLR_IRQ));
    hit_start = wr_en && (wr_addr == ADDR_W'(OFS_SET_START));
    clr_err_m   = hit_err   ? sel : '0;
    clr_irq_m   = hit_irq   ? sel : '0;
    set_start_m = hit_start ? sel : '0;
  end

  // R9: reserved channel numbers select nothing
  assert_reserved_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[6] && (32'(wr_data[5:0]) >= NUM_CH))
      |-> (clr_err_m == '0 && clr_irq_m == '0 && set_start_m == '0));

  // R2: a single-channel command touches at most one flag
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[6]) |-> ($countones(clr_err_m | clr_irq_m | set_start_m) <= 1));

  // R3: global clear-error selects every channel of the build
  assert_global_err_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(OFS_CLR_ERR) && wr_data[6])
      |-> ($countones(clr_err_m) == NUM_CH));

endmodule

// File: rtl/chan_flag_bank.sv
module chan_flag_bank #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_m,
  input  logic [WIDTH-1:0] clr_m,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;
  logic             q_en;

  // Set is applied after clear, so a same-cycle set wins.
  always_comb begin
    q_en  = (|set_m) || (|clr_m);
    q_nxt = (q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R8: any set request is visible next cycle, whatever clear came with it
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != '0) |=> ((q & $past(set_m)) == $past(set_m)));

  // R2: a clear with no competing set leaves the flag low
  assert_clear_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_m & ~set_m) != '0) |=> ((q & $past(clr_m & ~set_m)) == '0));

  // R10: with no request, the bank holds
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m == '0 && clr_m == '0) |=> $stable(q));

endmodule

// File: rtl/chan_flag_cmd.sv
module chan_flag_cmd
  import chan_flag_pkg::*;
#(
  parameter int unsigned NUM_CH        = 64,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned OFS_CLR_ERR   = 'h1D,
  parameter int unsigned OFS_CLR_IRQ   = 'h1F,
  parameter int unsigned OFS_SET_START = 'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [63:0]       err_evt,
  input  logic [63:0]       irq_evt,
  input  logic [63:0]       start_clr,
  output logic [31:0]       err_hi,
  output logic [31:0]       err_lo,
  output logic [31:0]       irq_hi,
  output logic [31:0]       irq_lo,
  output logic [63:0]       start_flags
);

  localparam chan_vec_t VALID = valid_mask(NUM_CH);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  chan_vec_t clr_err_m, clr_irq_m, set_start_m;
  chan_vec_t err_q, irq_q, start_q;
  chan_vec_t err_set, irq_set, start_drop;

  chan_cmd_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OFS_CLR_ERR(OFS_CLR_ERR),
    .OFS_CLR_IRQ(OFS_CLR_IRQ), .OFS_SET_START(OFS_SET_START)
  ) u_decode (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_err_m(clr_err_m), .clr_irq_m(clr_irq_m), .set_start_m(set_start_m)
  );

  always_comb begin
    err_set    = err_evt   & VALID;
    irq_set    = irq_evt   & VALID;
    start_drop = start_clr & VALID;
  end

  chan_flag_bank #(.WIDTH(MAX_CH)) u_err_bank (
    .clk(clk), .rst_n(rst_q), .set_m(err_set), .clr_m(clr_err_m), .q(err_q));

  chan_flag_bank #(.WIDTH(MAX_CH)) u_irq_bank (
    .clk(clk), .rst_n(rst_q), .set_m(irq_set), .clr_m(clr_irq_m), .q(irq_q));

  chan_flag_bank #(.WIDTH(MAX_CH)) u_start_bank (
    .clk(clk), .rst_n(rst_q), .set_m(set_start_m), .clr_m(start_drop), .q(start_q));

  assign err_hi      = err_q[MAX_CH-1:HALF_W];
  assign err_lo      = err_q[HALF_W-1:0];
  assign irq_hi      = irq_q[MAX_CH-1:HALF_W];
  assign irq_lo      = irq_q[HALF_W-1:0];
  assign start_flags = start_q;

  // R3: global clear-error with no event empties both halves
  assert_global_err_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && wr_addr == ADDR_W'(OFS_CLR_ERR) && wr_data[6] && err_evt == '0)
      |=> (err_hi == '0 && err_lo == '0));

  // R5: global clear-interrupt with no event empties the bank
  assert_global_irq_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && wr_addr == ADDR_W'(OFS_CLR_IRQ) && wr_data[6] && irq_evt == '0)
      |=> (irq_hi == '0 && irq_lo == '0));

  // R6: global set-start raises every start flag of the build
  assert_global_start_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && wr_addr == ADDR_W'(OFS_SET_START) && wr_data[6])
      |=> ($countones(start_flags) == NUM_CH));

  generate
    if (NUM_CH <= HALF_W) begin : g_reduced
      // R9: upper channels do not exist in the reduced build
      assert_hi_zero_R9: assert property (@(posedge clk) disable iff (!rst_q)
        (err_hi == '0 && irq_hi == '0 && start_flags[MAX_CH-1:HALF_W] == '0));
    end
  endgenerate

endmodule

// File: tb/chan_flag_cmd_bench.sv
`timescale 1ns/1ps
module chan_flag_cmd_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr, wr_data;
  logic [63:0] err_evt, irq_evt, start_clr;

  logic [31:0] eh64, el64, ih64, il64, eh32, el32, ih32, il32;
  logic [63:0] s64, s32;

  always #2.5 clk = ~clk;

  chan_flag_cmd u_chan_flag_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_evt(err_evt), .irq_evt(irq_evt), .start_clr(start_clr),
    .err_hi(eh64), .err_lo(el64), .irq_hi(ih64), .irq_lo(il64), .start_flags(s64));

  chan_flag_cmd #(.NUM_CH(32)) u_chan_flag_cmd_n32 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_evt(err_evt), .irq_evt(irq_evt), .start_clr(start_clr),
    .err_hi(eh32), .err_lo(el32), .irq_hi(ih32), .irq_lo(il32), .start_flags(s32));

  typedef struct {
    string       tag;
    logic [63:0] e [2];
    logic [63:0] i [2];
    logic [63:0] s [2];
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] me [2], mi [2], ms [2];
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  localparam logic [7:0] A_ERR = 8'h1D, A_IRQ = 8'h1F, A_START = 8'h1B;

  function automatic logic [63:0] vmask(int c);
    return (c == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
  endfunction

  // Flags a command selects, built from the channel-field rules.
  function automatic logic [63:0] pick(logic [7:0] d, int c);
    int n, ch;
    n  = (c == 0) ? 64 : 32;
    ch = int'(d[6:0]);
    if (ch >= 64) return vmask(c);
    if (ch < n)   return 64'd1 << ch;
    return 64'd0;
  endfunction

  task automatic op(string tag, logic we, logic [7:0] a, logic [7:0] d,
                    logic [63:0] ee, logic [63:0] ie, logic [63:0] sc);
    exp_t x;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    err_evt = ee; irq_evt = ie; start_clr = sc;
    for (int c = 0; c < 2; c++) begin
      logic [63:0] ce, ci, ss;
      ce = (we && a == A_ERR)   ? pick(d, c) : 64'd0;
      ci = (we && a == A_IRQ)   ? pick(d, c) : 64'd0;
      ss = (we && a == A_START) ? pick(d, c) : 64'd0;
      me[c] = (me[c] & ~ce) | (ee & vmask(c));
      mi[c] = (mi[c] & ~ci) | (ie & vmask(c));
      ms[c] = (ms[c] & ~(sc & vmask(c))) | ss;
      x.e[c] = me[c]; x.i[c] = mi[c]; x.s[c] = ms[c];
    end
    x.tag = tag;
    sb_q.push_back(x);
  endtask

  task automatic idle(string tag);
    op(tag, 1'b0, 8'h00, 8'h00, 64'd0, 64'd0, 64'd0);
  endtask

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: the outputs settle after the rising edge that follows each drive.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t x;
      x = sb_q.pop_front();
      cmp(x.tag, "err64",   {eh64, el64}, x.e[0]);
      cmp(x.tag, "irq64",   {ih64, il64}, x.i[0]);
      cmp(x.tag, "start64", s64,          x.s[0]);
      cmp(x.tag, "err32",   {eh32, el32}, x.e[1]);
      cmp(x.tag, "irq32",   {ih32, il32}, x.i[1]);
      cmp(x.tag, "start32", s32,          x.s[1]);
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin me[c] = '0; mi[c] = '0; ms[c] = '0; end
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    err_evt = '0; irq_evt = '0; start_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    idle("R1");
    op("R8", 1'b0, 8'h00, 8'h00, '1, '1, '0);
    op("R2", 1'b1, A_ERR, 8'd5, '0, '0, '0);
    op("R2/R9", 1'b1, A_ERR, 8'd40, '0, '0, '0);
    op("R7", 1'b1, A_ERR, 8'h86, '0, '0, '0);
    op("R4/R9", 1'b1, A_IRQ, 8'd63, '0, '0, '0);
    op("R4", 1'b1, A_IRQ, 8'd9, '0, '0, '0);
    op("R8", 1'b1, A_IRQ, 8'd0, '0, 64'h1, '0);
    op("R10", 1'b1, 8'h1C, 8'h40, '0, '0, '0);
    op("R10", 1'b0, A_ERR, 8'h40, '0, '0, '0);
    op("R3", 1'b1, A_ERR, 8'h7F, '0, '0, '0);
    op("R5", 1'b1, A_IRQ, 8'hC0, '0, '0, '0);
    op("R6", 1'b1, A_START, 8'd3, '0, '0, '0);
    op("R6/R9", 1'b1, A_START, 8'd33, '0, '0, '0);
    op("R11", 1'b0, 8'h00, 8'h00, '0, '0, 64'h8);
    op("R11", 1'b1, A_START, 8'd7, '0, '0, 64'h80);
    op("R6", 1'b1, A_START, 8'h55, '0, '0, '0);
    op("R11", 1'b0, 8'h00, 8'h00, '0, '0, 64'hF000_0000_0000_000F);
    idle("R10");

    while (sb_q.size() > 0) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule